// File: doc/BRIEF.md
# Sampled-Clock RAM Write Port

This block is a small single-write-port RAM. Its write strobe is an ordinary data signal that only behaves like a clock. All storage in the block updates on one fast global clock. Every global cycle the block registers the strobe level, the per-bit write enable, the write address and the write data. When the current strobe level and the registered level form the active-edge pattern, the block commits the enable, address and data that were captured one global cycle earlier. Those are the values that stood on the inputs just before the strobe edge. The read port has no register: the read data follows the read address within the same cycle.

The block is meant for places where a slow or derived write clock has to be folded into a single-clock domain. The global clock must sample the strobe often enough to see every level it takes. A parameter selects whether a rising or a falling strobe edge is active. The write-strobe history register and the captured enable come out of reset in a state that cannot produce a write. The array contents are never reset.

Top module: `sampled_clock_ram`

## Requirements
- R1: During reset and after its release, no write happens until the strobe makes a genuine active transition. The history register resets to the active level (1 for rising, 0 for falling). The captured enable resets to all zeros.
- R2: With `EDGE_POL = POL_RISE` (encoding 1), a write occurs on a global edge only if the strobe is 1 at that edge and was 0 at the previous global edge.
- R3: With `EDGE_POL = POL_FALL` (encoding 0), a write occurs on a global edge only if the strobe is 0 at that edge and was 1 at the previous global edge.
- R4: The committed enable, address and data are the values sampled at the global edge before the one that sees the strobe transition. Values changed together with the strobe edge are not the ones written.
- R5: The enable is per bit: data bit i is written only when enable bit i is 1. Bits whose enable is 0 keep their stored value.
- R6: While the strobe holds one level, nothing is written, whatever the enable, address and data do.
- R7: The read data equals the array word at the read address within the same cycle, with no register on the read path.
- R8: A committed write is visible on the read port right after the global edge that commits it.
- R9: A strobe pulse that lasts many global cycles causes exactly one write, at its active transition. Data changed while the strobe stays at the active level is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock; all registers and the array update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the sampling registers (not the array) |
| wr_clk | input | 1 | Write strobe, sampled as data every global cycle |
| wr_en | input | DATA_W | Per-bit write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |

## Verification
Four properties are checked on every global cycle:
- the history register takes the active level out of reset;
- any effective write coincides with the active strobe pattern;
- a steady strobe never writes;
- when the read address matches the captured write address, enabled bits show the captured data one cycle later and disabled bits stay unchanged.

Other behaviours only show up in the bench's scenarios, which run one stimulus through a rising and a falling instance side by side:
- the written values are the ones from before the strobe edge;
- a long pulse gives exactly one write;
- the contents survive a reset taken at either strobe level.

// File: rtl/scr_pkg.sv
package scr_pkg;
    // Active edge selection for the sampled write strobe
    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } edge_pol_e;
endpackage

// File: rtl/scr_capture.sv
// Registers strobe level, enable, address and data every global cycle.
module scr_capture #(
    parameter int   AW       = 4,
    parameter int   DW       = 8,
    parameter logic HIST_RST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_clk,
    input  logic [DW-1:0] wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          hist_q,
    output logic [DW-1:0] en_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    typedef struct packed {
        logic          hist;
        logic [DW-1:0] en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.hist = wr_clk;
        smp_d.en   = wr_en;
        smp_d.addr = wr_addr;
        smp_d.data = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q.hist <= HIST_RST;
            smp_q.en   <= '0;
            smp_q.addr <= '0;
            smp_q.data <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign hist_q = smp_q.hist;
    assign en_q   = smp_q.en;
    assign addr_q = smp_q.addr;
    assign data_q = smp_q.data;
endmodule

// File: rtl/scr_edge_detect.sv
// Gates the captured enable with the active-edge pattern of the strobe.
module scr_edge_detect #(
    parameter int                DW  = 8,
    parameter scr_pkg::edge_pol_e POL = scr_pkg::POL_RISE
) (
    input  logic          wr_clk,
    input  logic          hist_q,
    input  logic [DW-1:0] en_q,
    output logic [DW-1:0] we_eff
);
    logic hit;

    if (POL == scr_pkg::POL_RISE) begin : g_rise
        assign hit = wr_clk & ~hist_q;
    end else begin : g_fall
        assign hit = ~wr_clk & hist_q;
    end

    assign we_eff = hit ? en_q : '0;
endmodule

// File: rtl/scr_storage.sv
// Word array with bit-masked synchronous write and combinational read.
module scr_storage #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic [DW-1:0] we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] row_d;

    always_comb begin
        row_d = (mem[waddr] & ~we) | (wdata & we);
    end

    always_ff @(posedge clk) begin
        if (|we) begin
            mem[waddr] <= row_d;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sampled_clock_ram.sv
module sampled_clock_ram #(
    parameter int                 ADDR_W   = 4,
    parameter int                 DATA_W   = 8,
    parameter scr_pkg::edge_pol_e EDGE_POL = scr_pkg::POL_RISE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic [DATA_W-1:0] wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    // History starts at the active level so the first sample cannot look like an edge
    localparam logic HIST_INIT = (EDGE_POL == scr_pkg::POL_RISE) ? 1'b1 : 1'b0;

    logic              hist_q;
    logic [DATA_W-1:0] en_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] we_eff;

    scr_capture #(
        .AW(ADDR_W), .DW(DATA_W), .HIST_RST(HIST_INIT)
    ) u_capture (
        .clk(clk), .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .hist_q(hist_q), .en_q(en_q), .addr_q(addr_q), .data_q(data_q)
    );

    scr_edge_detect #(
        .DW(DATA_W), .POL(EDGE_POL)
    ) u_edge (
        .wr_clk(wr_clk), .hist_q(hist_q), .en_q(en_q), .we_eff(we_eff)
    );

    scr_storage #(
        .AW(ADDR_W), .DW(DATA_W)
    ) u_storage (
        .clk(clk), .we(we_eff), .waddr(addr_q), .wdata(data_q),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
    parameter int   AW  = 4,
    parameter int   DW  = 8,
    parameter logic ACT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_clk,
    input logic          hist_q,
    input logic [DW-1:0] we_eff,
    input logic [AW-1:0] addr_q,
    input logic [DW-1:0] data_q,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data
);
    // R1: history register sits at the active level out of reset
    assert_hist_init_R1: assert property (@(posedge clk)
        !rst_n |=> (hist_q == ACT));

    // R2 (rising) and R3 (falling): a write needs the active transition pattern
    assert_write_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|we_eff) |-> ((wr_clk == ACT) && (hist_q != ACT)));

    // R6: a steady strobe never writes
    assert_steady_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clk == hist_q) |-> (we_eff == '0));

    // R8: enabled bits show the captured data after the committing edge
    assert_commit_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == addr_q) |=> ((rd_addr != $past(rd_addr)) ||
            (((rd_data ^ $past(data_q)) & $past(we_eff)) == '0)));

    // R5: disabled bits keep their value across the edge
    assert_keep_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == addr_q) |=> ((rd_addr != $past(rd_addr)) ||
            (((rd_data ^ $past(rd_data)) & ~$past(we_eff)) == '0)));
endmodule

bind sampled_clock_ram scr_checker #(
    .AW(ADDR_W), .DW(DATA_W), .ACT(HIST_INIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_clk(wr_clk), .hist_q(hist_q),
    .we_eff(we_eff), .addr_q(addr_q), .data_q(data_q),
    .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sampled_clock_ram_tb.sv
module sampled_clock_ram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rst_req = 1'b0;
    logic          wr_clk = 1'b0;
    logic [DW-1:0] wr_en = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_rise, rd_fall;

    int nvec = 0;
    int nfail = 0;

    // Reference state: index 0 = rising instance, 1 = falling instance
    logic [DW-1:0] m_mem   [2][DEPTH];
    logic [DW-1:0] m_known [2][DEPTH];
    logic          p_hist  [2];
    logic [DW-1:0] p_en;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    sampled_clock_ram #(.ADDR_W(AW), .DATA_W(DW), .EDGE_POL(scr_pkg::POL_RISE)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_rise)
    );

    sampled_clock_ram #(.ADDR_W(AW), .DATA_W(DW), .EDGE_POL(scr_pkg::POL_FALL)) u_dut_fall (
        .clk(clk), .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_fall)
    );

    function automatic logic act_lvl(input int k);
        return (k == 0) ? 1'b1 : 1'b0;
    endfunction

    task automatic reset_prev();
        for (int k = 0; k < 2; k++) p_hist[k] = act_lvl(k);
        p_en = '0;
        p_addr = '0;
        p_data = '0;
    endtask

    // One global cycle: drive at negedge, compare the same-cycle read, then
    // advance the model to the state the next rising edge produces.
    task automatic step(input logic c, input logic [DW-1:0] en, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [AW-1:0] ra, input string tag);
        logic [DW-1:0] got;
        logic [DW-1:0] exp;
        @(negedge clk);
        rst_n = rst_req;
        wr_clk = c; wr_en = en; wr_addr = a; wr_data = d; rd_addr = ra;
        #1;
        for (int k = 0; k < 2; k++) begin
            got = (k == 0) ? rd_rise : rd_fall;
            exp = m_mem[k][ra];
            nvec++;
            if (((got ^ exp) & m_known[k][ra]) != '0) begin
                nfail++;
                $display("FAIL %s pol=%s addr=%0d actual=%h expected=%h mask=%h",
                         tag, (k == 0) ? "rise" : "fall", ra, got, exp, m_known[k][ra]);
            end
        end
        if (rst_req) begin
            for (int k = 0; k < 2; k++) begin
                if ((c == act_lvl(k)) && (p_hist[k] != act_lvl(k))) begin
                    for (int b = 0; b < DW; b++) begin
                        if (p_en[b]) begin
                            m_mem[k][p_addr][b] = p_data[b];
                            m_known[k][p_addr][b] = 1'b1;
                        end
                    end
                end
                p_hist[k] = c;
            end
            p_en = en; p_addr = a; p_data = d;
        end else begin
            reset_prev();
        end
    endtask

    task automatic pulse(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [DW-1:0] en, input string tag);
        step(1'b0, en, a, d, AW'($urandom), tag);
        step(1'b0, en, a, d, a, tag);
        step(1'b1, en, a, d, a, tag);
        step(1'b1, en, a, d, a, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog expired before the scenarios finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic cl;
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < DEPTH; i++) begin
                m_mem[k][i] = '0;
                m_known[k][i] = '0;
            end
        reset_prev();

        // R1: reset with enable high, then release
        rst_req = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b1, '1, 4'd0, 8'hAA, 4'd0, "R1 reset");
        rst_req = 1'b1;

        // R2 R3 R8: fill every word; falling instance stores at the next fall
        for (int a = 0; a < DEPTH; a++)
            pulse(AW'(a), DW'(a * 17) ^ 8'h5C, '1, "R2 R3 R8 fill");
        step(1'b0, '0, 4'd0, 8'h00, 4'd15, "R3 fill tail");
        step(1'b0, '0, 4'd0, 8'h00, 4'd14, "R3 fill tail");

        // R5: partial per-bit enables
        for (int i = 0; i < 8; i++)
            pulse(AW'(i), 8'hF0 ^ DW'(i), 8'h0F << (i % 5), "R5 mask");
        step(1'b0, '0, 4'd0, 8'h00, 4'd7, "R5 tail");

        // R4: data and address change together with the strobe edges
        for (int i = 0; i < 4; i++) begin
            step(1'b0, '1, AW'(i), 8'h33, AW'(i), "R4 setup");
            step(1'b0, '1, AW'(i), 8'h33, AW'(i), "R4 setup");
            step(1'b1, '1, AW'(i), 8'hCC, AW'(i), "R4 rise");
            step(1'b1, '1, AW'(i + 8), 8'hCC, AW'(i), "R4 high");
            step(1'b0, '1, AW'(i + 8), 8'h99, AW'(i + 8), "R4 fall");
            step(1'b0, '0, AW'(i + 8), 8'h99, AW'(i + 8), "R4 low");
        end

        // R6: steady strobe, busy inputs
        for (int i = 0; i < 20; i++)
            step(1'b1, DW'($urandom), AW'($urandom), DW'($urandom), AW'($urandom), "R6 high");
        for (int i = 0; i < 20; i++)
            step(1'b0, DW'($urandom), AW'($urandom), DW'($urandom), AW'($urandom), "R6 low");

        // R9: long pulse with data churning while high
        step(1'b0, '1, 4'd3, 8'h42, 4'd3, "R9 setup");
        step(1'b1, '1, 4'd3, 8'h42, 4'd3, "R9 rise");
        for (int i = 0; i < 8; i++)
            step(1'b1, '1, 4'd3, DW'($urandom), 4'd3, "R9 held");
        step(1'b0, '0, 4'd3, 8'h00, 4'd3, "R9 fall");
        step(1'b0, '0, 4'd3, 8'h00, 4'd3, "R9 after");

        // R1: reset at each strobe level keeps contents, no spurious write
        for (int lv = 0; lv < 2; lv++) begin
            rst_req = 1'b0;
            for (int i = 0; i < 3; i++) step(1'(lv), '1, AW'(i), 8'h00, AW'(i), "R1 in reset");
            rst_req = 1'b1;
            for (int i = 0; i < 6; i++) step(1'(lv), '1, AW'(i), 8'h00, AW'(i), "R1 after release");
        end

        // R7: same-cycle reads across the whole array
        for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 4'd0, 8'h00, AW'(DEPTH - 1 - i), "R7 sweep");

        // R2 R3 R5: random traffic with slow strobe
        cl = 1'b0;
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            if ($urandom % 3 == 0) cl = ~cl;
            a = AW'($urandom);
            step(cl, DW'($urandom), a, DW'($urandom),
                 ($urandom % 2 == 0) ? a : AW'($urandom), "R2 R3 R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule